// File: doc/BRIEF.md
# DSCP to Traffic-Identifier Lookup Table

This block turns the 6-bit differentiated-services code point of an outgoing frame into a 3-bit traffic identifier (TID). It holds two independent tables of 64 entries each. Each frame picks its table with a one-bit select. Software loads the tables through a word-wide register port. The entries are packed tightly, three bits each, so one table fills exactly six 32-bit words. Table 0 sits in words 0 to 5 and table 1 in words 6 to 11. Some entries therefore cross a word boundary.

Table programming is guarded by a small two-state machine. In state LOCKED, the map words are read-only. Writing a 1 to bit 0 of the control register at word address 12 moves the machine to OPEN, where map writes are accepted. Writing a 0 to that bit moves it back to LOCKED. A control write whose bit 0 matches the current state leaves the state as it is (LOCKED to LOCKED, OPEN to OPEN). To change a single entry, software reads the word or pair of words that hold it, replaces only those three bits, and writes the words back while the machine is OPEN.

Lookups are registered. A strobe with a code point and a table select produces the TID one clock later, taken from the table contents present on the strobe cycle.

Top module: `dscp_tid_map`

## Requirements
- R1: After reset, every map word reads 0. The control register reads 0, the state is LOCKED, `res_valid` is low, and every lookup returns TID 0.
- R2: While the state is OPEN, a write to word address 0 to 11 replaces the whole 32-bit word. A later read of that address returns the written value.
- R3: While the state is LOCKED, a write to word address 0 to 11 is ignored. The stored words and all lookup results stay unchanged.
- R4: The control register is at word address 12. Bit 0 is the program enable: writing 1 gives OPEN and writing 0 gives LOCKED, from the next clock edge. A read of address 12 returns `{31'b0, enable}`.
- R5: For table t, words 6t to 6t+5 form a 192-bit image, with word 6t+n holding image bits 32n to 32n+31. The entry for code point k is image bits 3k+2 down to 3k, with 3k as the least significant TID bit.
- R6: An entry that crosses a word boundary (k = 10, 21, 42, 53) takes its low bits from the top of the lower word and its high bits from the bottom of the next word.
- R7: `lk_table` = 0 selects words 0 to 5 and `lk_table` = 1 selects words 6 to 11, independently on every lookup.
- R8: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. `res_tid` then reflects the table as it was on the strobe cycle, so a map write in that same cycle is not seen.
- R9: Word addresses 13 to 31 read as 0. A write to one of them changes neither the map words nor the enable.
- R10: Map words and the control register can be read in either state, and a read never changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lk_valid | input | 1 | Lookup strobe |
| lk_dscp | input | 6 | Code point to translate |
| lk_table | input | 1 | Table select for this lookup |
| res_valid | output | 1 | Lookup result valid, one cycle after the strobe |
| res_tid | output | 3 | Traffic identifier |

## Verification
Two kinds of fault show up at the ports. A stuck or wrongly decoded enable state appears in the very next read of address 12, or as a map word that does or does not change after a write, visible on the next read. A misplaced bit offset or table base never shows in register reads: it only appears as a wrong TID one cycle after a lookup of the affected code point. For that reason every code point of both tables is looked up against packed contents that differ in every word, with the four boundary-crossing entries singled out. The same-cycle write-and-lookup case exposes a result path that samples the table after the write instead of before it.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } prog_state_t;
endpackage

// File: rtl/dtm_ctrl.sv
module dtm_ctrl
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic prog_en
);
    prog_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (ctrl_wr && ctrl_bit)  state_d = ST_OPEN;
            ST_OPEN:   if (ctrl_wr && !ctrl_bit) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        prog_en = (state_q == ST_OPEN);
    end
endmodule

// File: rtl/dtm_store.sv
module dtm_store #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 12,
    parameter int ADDR_W    = 5,
    localparam int IMG_BITS = WORD_W * NUM_WORDS,
    localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                rd_hit,
    output logic [IMG_BITS-1:0] image
);
    logic [WORD_W-1:0] words [NUM_WORDS];
    logic              in_range;

    assign in_range = (addr < ADDR_W'(NUM_WORDS));
    assign rd_hit   = in_range;

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    words[g] <= '0;
                else if (wr_en && in_range && (addr[WIDX_W-1:0] == WIDX_W'(g)))
                    words[g] <= wdata;
            end
            assign image[g*WORD_W +: WORD_W] = words[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (in_range && (addr[WIDX_W-1:0] == WIDX_W'(i)))
                rdata = words[i];
    end
endmodule

// File: rtl/dtm_lookup.sv
module dtm_lookup #(
    parameter int IMG_BITS   = 384,
    parameter int TABLE_BITS = 192,
    parameter int KEY_W      = 6,
    parameter int VAL_W      = 3,
    parameter int SEL_W      = 1,
    localparam int IDX_W     = $clog2(IMG_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IMG_BITS-1:0] image,
    input  logic                valid_in,
    input  logic [KEY_W-1:0]    key,
    input  logic [SEL_W-1:0]    sel,
    output logic                valid_out,
    output logic [VAL_W-1:0]    value
);
    logic [IDX_W-1:0] base;
    logic [VAL_W-1:0] picked;

    always_comb begin
        base   = IDX_W'(sel) * IDX_W'(TABLE_BITS) + IDX_W'(key) * IDX_W'(VAL_W);
        picked = image[base +: VAL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            value     <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) value <= picked;
        end
    end
endmodule

// File: rtl/dscp_tid_map.sv
module dscp_tid_map #(
    parameter int KEY_W      = 6,
    parameter int TID_W      = 3,
    parameter int NUM_TABLES = 2,
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 5,
    localparam int ENTRIES    = 1 << KEY_W,
    localparam int TABLE_BITS = ENTRIES * TID_W,
    localparam int TBL_WORDS  = TABLE_BITS / WORD_W,
    localparam int NUM_WORDS  = TBL_WORDS * NUM_TABLES,
    localparam int IMG_BITS   = NUM_WORDS * WORD_W,
    localparam int SEL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1,
    localparam int CTRL_ADDR  = NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_dscp,
    input  logic [SEL_W-1:0]  lk_table,
    output logic              res_valid,
    output logic [TID_W-1:0]  res_tid
);
    logic                prog_en;
    logic                ctrl_hit;
    logic                map_rd_hit;
    logic [WORD_W-1:0]   map_rdata;
    logic [IMG_BITS-1:0] map_img;

    assign ctrl_hit = (reg_addr == ADDR_W'(CTRL_ADDR));

    dtm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (reg_wr && ctrl_hit),
        .ctrl_bit (reg_wdata[0]),
        .prog_en  (prog_en)
    );

    dtm_store #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && prog_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (map_rdata),
        .rd_hit (map_rd_hit),
        .image  (map_img)
    );

    dtm_lookup #(
        .IMG_BITS   (IMG_BITS),
        .TABLE_BITS (TABLE_BITS),
        .KEY_W      (KEY_W),
        .VAL_W      (TID_W),
        .SEL_W      (SEL_W)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .image     (map_img),
        .valid_in  (lk_valid),
        .key       (lk_dscp),
        .sel       (lk_table),
        .valid_out (res_valid),
        .value     (res_tid)
    );

    always_comb begin
        if (map_rd_hit)    reg_rdata = map_rdata;
        else if (ctrl_hit) reg_rdata = {{(WORD_W-1){1'b0}}, prog_en};
        else               reg_rdata = '0;
    end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int IMG_BITS  = 384,
    parameter int CTRL_ADDR = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [WORD_W-1:0]   reg_rdata,
    input logic                lk_valid,
    input logic                res_valid,
    input logic                prog_en,
    input logic [IMG_BITS-1:0] map_img
);
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(map_img)); // R3
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR) && reg_wdata[0]) |=> prog_en); // R4
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR) && !reg_wdata[0]) |=> !prog_en); // R4
    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(CTRL_ADDR)) |-> (reg_rdata == {{(WORD_W-1){1'b0}}, prog_en})); // R4
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(CTRL_ADDR)) |-> (reg_rdata == '0)); // R9
    AST_OOR_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr > ADDR_W'(CTRL_ADDR)) |=> ($stable(map_img) && $stable(prog_en))); // R9
    AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R8
    AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R8
    AST_READ_SIDE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(map_img) && $stable(prog_en))); // R10
endmodule

bind dscp_tid_map dtm_checker #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .IMG_BITS  (IMG_BITS),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .prog_en   (prog_en),
    .map_img   (map_img)
);

// File: tb/sim_dscp_tid_map.sv
module sim_dscp_tid_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [5:0]  lk_dscp = '0;
    logic        lk_table = 1'b0;
    logic        res_valid;
    logic [2:0]  res_tid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [12];
    bit          model_en = 1'b0;
    logic [2:0]  exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    dscp_tid_map u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_dscp(lk_dscp), .lk_table(lk_table), .res_valid(res_valid),
        .res_tid(res_tid)
    );

    function automatic logic [2:0] model_tid(input logic t, input logic [5:0] d);
        logic [383:0] img;
        for (int i = 0; i < 12; i++) img[i*32 +: 32] = model[i];
        return img[int'(t)*192 + int'(d)*3 +: 3];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a < 12 && model_en) model[a] = d;
        if (a == 12) model_en = d[0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic lookup(input logic t, input logic [5:0] d, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_table = t; lk_dscp = d;
        exp_q.push_back(model_tid(t, d));
        tag_q.push_back(tag);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 actual=res_valid=1 expected=res_valid=0");
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {29'b0, res_tid}, {29'b0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 res_valid", {31'b0, res_valid}, 32'd0);
        for (int i = 0; i < 12; i++) reg_check(5'(i), 32'd0, "R1 word");
        reg_check(5'd12, 32'd0, "R1 ctrl");
        lookup(1'b0, 6'd5, "R1 lookup t0");
        lookup(1'b1, 6'd63, "R1 lookup t1");

        // R3: locked writes ignored
        reg_write(5'd0, 32'hFFFF_FFFF);
        reg_check(5'd0, 32'd0, "R3 locked write");
        lookup(1'b0, 6'd0, "R3 lookup after locked write");

        // R4: enable
        reg_write(5'd12, 32'h0000_0001);
        reg_check(5'd12, 32'd1, "R4 ctrl set");

        // R2: program all words
        for (int i = 0; i < 12; i++)
            reg_write(5'(i), 32'h9E37_79B9 * (i + 1) ^ (32'h0101_0101 << i));
        for (int i = 0; i < 12; i++) reg_check(5'(i), model[i], "R2 readback");

        // R4 clear, R10 reads while locked
        reg_write(5'd12, 32'hFFFF_FFFE);
        reg_check(5'd12, 32'd0, "R4 ctrl clear");
        for (int i = 0; i < 12; i++) reg_check(5'(i), model[i], "R10 read locked");

        // R5, R7, R6: every entry of both tables
        for (int t = 0; t < 2; t++)
            for (int d = 0; d < 64; d++)
                lookup(1'(t), 6'(d),
                       (d == 10 || d == 21 || d == 42 || d == 53) ? "R6 straddle" :
                       (t == 1) ? "R7 table1" : "R5 table0");

        // R3: locked write to programmed word
        reg_write(5'd3, 32'h1234_5678);
        reg_check(5'd3, model[3], "R3 locked word3");
        lookup(1'b0, 6'd42, "R3 lookup entry42");

        // R9: out of range
        reg_write(5'd13, 32'h0000_0001);
        reg_write(5'd31, 32'hFFFF_FFFF);
        reg_check(5'd13, 32'd0, "R9 read 13");
        reg_check(5'd31, 32'd0, "R9 read 31");
        reg_check(5'd12, 32'd0, "R9 ctrl untouched");
        reg_check(5'd1, model[1], "R9 word untouched");

        // R6: single-entry update of straddling entry 10 in table 1 (value 3'b101)
        reg_write(5'd12, 32'd1);
        reg_write(5'd6, {2'b01, model[6][29:0]});
        reg_write(5'd7, {model[7][31:1], 1'b1});
        lookup(1'b1, 6'd9, "R6 neighbour 9");
        lookup(1'b1, 6'd10, "R6 entry10 update");
        lookup(1'b1, 6'd11, "R6 neighbour 11");
        check("R6 entry10 model", {29'b0, model_tid(1'b1, 6'd10)}, 32'd5);

        // R8: write and lookup on the same cycle sees the old contents
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h0000_0007;
        lk_valid = 1'b1; lk_table = 1'b0; lk_dscp = 6'd0;
        exp_q.push_back(model_tid(1'b0, 6'd0));
        tag_q.push_back("R8 same-cycle write");
        model[0] = 32'h0000_0007;
        @(negedge clk);
        reg_wr = 1'b0; lk_valid = 1'b0;
        lookup(1'b0, 6'd0, "R8 after write");
        // back-to-back lookups
        @(negedge clk);
        lk_valid = 1'b1; lk_table = 1'b1; lk_dscp = 6'd21;
        exp_q.push_back(model_tid(1'b1, 6'd21)); tag_q.push_back("R8 b2b first");
        @(negedge clk);
        lk_dscp = 6'd53;
        exp_q.push_back(model_tid(1'b1, 6'd53)); tag_q.push_back("R8 b2b second");
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 queue drained", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule